// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt lines into a single interrupt output. Each line has three state bits: a pending-request bit, an in-service bit and a mask bit. A controller-wide mode bit selects how requests are detected. In edge mode a rising edge latches a request. In level mode the request bit follows the line. A fixed-priority resolver, with line 0 as the most urgent, raises the output for the most urgent unmasked request. It does so only when no line of equal or higher urgency is already being serviced.

The processor side answers with two acknowledge strobes. The first strobe captures the winner of arbitration, so that requests arriving afterwards cannot change it. The second strobe returns an 8-bit vector for that winner and moves the line from pending to in-service. A non-specific end-of-interrupt strobe then retires the most urgent in-service line. Software sets the mask, the vector base and the trigger mode through a small write port.

Top module: `pic8_core`

## Requirements
- R1: After reset every request and in-service bit is clear, every mask bit is set, and int_out, vec_valid and vec_out are 0.
- R2: In edge mode (mode bit 0 = 0) a request latches on a 0-to-1 transition of its line. A line that stays high after being serviced does not request again.
- R3: In level mode (mode bit 0 = 1) the request bit follows the line level. A line still high when its in-service bit is retired by end-of-interrupt requests again.
- R4: Mask bit i = 1 blocks line i from int_out, but its request is still latched. Clearing the mask bit later raises int_out for that request.
- R5: Priority is fixed with line 0 highest. A pending line drives int_out only when no line of equal or higher priority is in service.
- R6: The first acknowledge strobe freezes the arbitration winner. A higher-priority request arriving before the second strobe does not change the returned vector.
- R7: On the second strobe, vec_valid pulses for one cycle and vec_out = {base[7:3], line index}. The index is line 0 = 000 through line 7 = 111. The winner's in-service bit is set and its request bit is cleared.
- R8: int_out is low in the cycle vec_valid is high. On the following clock it reflects the new arbitration result.
- R9: An eoi strobe clears the highest-priority in-service bit that is set, and only that bit.
- R10: If the frozen winner's request has gone by the second strobe, the vector index is 111 and no in-service bit is set.
- R11: A write with wr_en selects its target by wr_sel: 0 loads the mask from wr_data, 1 loads the vector base from wr_data[7:3], and 2 loads the mode from wr_data[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 8 | Write data |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| ack | input | 1 | Acknowledge strobe, two per acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | One-cycle strobe marking vec_out as new |

## Verification
Several properties are checked on every cycle. A rise of int_out must trace back to an unmasked pending request. A vector strobe must follow a second acknowledge strobe and must carry the programmed base with int_out low. At most one in-service bit may appear per cycle, and an end-of-interrupt that does not coincide with an acknowledge must remove exactly one in-service bit. The bench scenarios are needed to show the rest: which line wins, that the winner is frozen, that the blocking from in-service lines behaves as specified, that EOI clears the right bit, that level and edge lines re-request as specified, and that the vanished-winner case returns index 111.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_BASE = 2'd1,
        SEL_MODE = 2'd2
    } wsel_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_FROZEN = 1'b1
    } ack_ph_e;
endpackage

// File: rtl/pic8_trig.sv
module pic8_trig #(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] irq,
    input  logic [N_LINES-1:0] prv,
    input  logic [N_LINES-1:0] irr_q,
    input  logic               lvl,
    output logic [N_LINES-1:0] irr_nx
);
    // One detector per line; the mode bit is shared by all lines.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign irr_nx[i] = lvl ? irq[i] : (irr_q[i] | (irq[i] & ~prv[i]));
    end
endmodule

// File: rtl/pic8_pick.sv
module pic8_pick #(
    parameter int N_LINES = 8,
    localparam int IDX_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Lowest index wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic8_core.sv
module pic8_core #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [VEC_W-1:0]   wr_data,
    input  logic               eoi,
    input  logic               ack,
    output logic               int_out,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_valid
);
    import pic8_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0] irr;
        logic [N_LINES-1:0] isr;
        logic [N_LINES-1:0] imr;
        logic [N_LINES-1:0] prv;
        logic [BASE_W-1:0]  base;
        logic               lvl;
        ack_ph_e            ph;
        logic [IDX_W-1:0]   win;
        logic               win_ok;
        logic               intr;
        logic [VEC_W-1:0]   vec;
        logic               vvld;
    } st_t;

    st_t st_q, st_d;

    logic [N_LINES-1:0] irr_upd;
    logic               p_any, s_any, req_ok;
    logic [IDX_W-1:0]   p_idx, s_idx;

    pic8_trig #(.N_LINES(N_LINES)) u_trig (
        .irq    (irq_in),
        .prv    (st_q.prv),
        .irr_q  (st_q.irr),
        .lvl    (st_q.lvl),
        .irr_nx (irr_upd)
    );

    pic8_pick #(.N_LINES(N_LINES)) u_pend (
        .req (st_q.irr & ~st_q.imr),
        .any (p_any),
        .idx (p_idx)
    );

    pic8_pick #(.N_LINES(N_LINES)) u_serv (
        .req (st_q.isr),
        .any (s_any),
        .idx (s_idx)
    );

    // A request only counts if it outranks every line in service.
    assign req_ok = p_any && (!s_any || (p_idx < s_idx));

    always_comb begin
        st_d      = st_q;
        st_d.prv  = irq_in;
        st_d.irr  = irr_upd;
        st_d.vvld = 1'b0;
        st_d.intr = req_ok;

        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_MASK: st_d.imr  = wr_data[N_LINES-1:0];
                SEL_BASE: st_d.base = wr_data[VEC_W-1:IDX_W];
                SEL_MODE: st_d.lvl  = wr_data[0];
                default:  ;
            endcase
        end

        if (eoi && s_any) begin
            st_d.isr[s_idx] = 1'b0;
        end

        case (st_q.ph)
            PH_IDLE: begin
                if (ack) begin
                    st_d.ph     = PH_FROZEN;
                    st_d.win    = p_idx;
                    st_d.win_ok = req_ok;
                    st_d.intr   = st_q.intr;
                end
            end
            PH_FROZEN: begin
                st_d.intr = st_q.intr;
                if (ack) begin
                    st_d.ph   = PH_IDLE;
                    st_d.vvld = 1'b1;
                    st_d.intr = 1'b0;
                    if (st_q.win_ok && st_q.irr[st_q.win]) begin
                        st_d.isr[st_q.win] = 1'b1;
                        st_d.irr[st_q.win] = 1'b0;
                        st_d.vec = {st_q.base, st_q.win};
                    end else begin
                        st_d.vec = {st_q.base, {IDX_W{1'b1}}};
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.imr <= '1;
            st_q.ph  <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_out   = st_q.intr;
    assign vec_out   = st_q.vec;
    assign vec_valid = st_q.vvld;

    // R4: a new interrupt must come from an unmasked pending request
    a_r4_int_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_out) |-> $past(|(st_q.irr & ~st_q.imr)));

    // R7: the vector strobe only follows a second acknowledge strobe
    a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> ($past(ack) && $past(st_q.ph == PH_FROZEN)));

    // R7: the vector carries the base that was programmed
    a_r7_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> (vec_out[VEC_W-1:IDX_W] == $past(st_q.base)));

    // R7: at most one in-service bit appears per cycle
    a_r7_one_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 $onehot0(st_q.isr & ~$past(st_q.isr)));

    // R8: the interrupt output is low while the vector is presented
    a_r8_int_low_on_vec: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !int_out);

    // R9: an end-of-interrupt alone removes exactly one in-service bit
    a_r9_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (st_q.isr != '0) && !(ack && st_q.ph == PH_FROZEN)) |=>
        ($countones(st_q.isr) + 1 == $countones($past(st_q.isr))));
endmodule

// File: tb/sim_pic8_core.sv
`timescale 1ns/1ps
module sim_pic8_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       eoi;
    logic       ack;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pic8_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .eoi       (eoi),
        .ack       (ack),
        .int_out   (int_out),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    // Row: {mask, base, irq pattern, expected vector}, edge mode
    localparam logic [31:0] ROWS [6] = '{
        32'h00_20_01_20,
        32'h00_48_80_4F,
        32'h00_08_28_0B,
        32'h08_08_28_0D,
        32'h00_FF_40_FE,
        32'h00_70_FF_70
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; irq_in = '0; wr_en = 0; wr_sel = '0; wr_data = '0;
        eoi = 0; ack = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic ack_one;
        ack = 1; step(1); ack = 0;
    endtask

    task automatic ack_pair;
        ack_one; step(1); ack_one;
    endtask

    task automatic eoi_one;
        eoi = 1; step(1); eoi = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got 01 expected 00");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset;
        chk("R1 int", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        chk("R1 vec", vec_out, 8'h00);
        // R4 masked request latched but silent (R1 mask default set)
        irq_in = 8'h04; step(3);
        chk("R4 masked int", {7'd0, int_out}, 8'h00);
        wr(2'd0, 8'h00); step(2);
        chk("R4 unmask int", {7'd0, int_out}, 8'h01);
        ack_pair;
        chk("R7 vec line2", vec_out, 8'h02);
        chk("R7 vec_valid", {7'd0, vec_valid}, 8'h01);
        step(1);
        chk("R7 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);

        // Table of R7/R5/R11 cases
        foreach (ROWS[k]) begin
            do_reset;
            wr(2'd1, ROWS[k][23:16]);
            wr(2'd0, ROWS[k][31:24]);
            irq_in = ROWS[k][15:8]; step(3);
            chk("R5 table int", {7'd0, int_out}, 8'h01);
            ack_pair;
            chk("R7 R11 table vec", vec_out, ROWS[k][7:0]);
            chk("R8 table int low", {7'd0, int_out}, 8'h00);
        end

        // R6 freeze, R8 re-evaluate, R9 and R5 nesting, R2 no retrigger
        do_reset;
        wr(2'd0, 8'h00); wr(2'd1, 8'h10);
        irq_in = 8'h10; step(3);
        ack_one; step(1);
        irq_in = 8'h12; step(1);
        ack_one;
        chk("R6 frozen winner", vec_out, 8'h14);
        chk("R8 int low on vec", {7'd0, int_out}, 8'h00);
        step(1);
        chk("R8 re-eval nested", {7'd0, int_out}, 8'h01);
        ack_pair;
        chk("R5 nested vec", vec_out, 8'h11);
        eoi_one;
        irq_in = 8'h16; step(3);
        chk("R9 eoi cleared line1", {7'd0, int_out}, 8'h01);
        ack_pair;
        chk("R9 line2 vec", vec_out, 8'h12);
        eoi_one; step(2);
        irq_in = 8'h56; step(3);
        chk("R5 blocked by line4", {7'd0, int_out}, 8'h00);
        eoi_one; step(2);
        chk("R9 line4 retired", {7'd0, int_out}, 8'h01);
        ack_pair;
        chk("R5 line6 vec", vec_out, 8'h16);
        eoi_one; step(4);
        chk("R2 held lines no retrigger", {7'd0, int_out}, 8'h00);

        // R3 level mode, R10 vanished winner
        do_reset;
        wr(2'd2, 8'h01); wr(2'd0, 8'h00);
        irq_in = 8'h08; step(3);
        chk("R3 level int", {7'd0, int_out}, 8'h01);
        ack_pair;
        chk("R3 level vec", vec_out, 8'h03);
        step(2);
        chk("R3 blocked by own service", {7'd0, int_out}, 8'h00);
        eoi_one; step(3);
        chk("R3 level re-request", {7'd0, int_out}, 8'h01);
        ack_one; step(1);
        irq_in = 8'h00; step(2);
        ack_one;
        chk("R10 vanished vec", vec_out, 8'h07);
        step(1);
        irq_in = 8'h20; step(3);
        chk("R10 no in-service set", {7'd0, int_out}, 8'h01);
        ack_pair;
        chk("R10 follow-up vec", vec_out, 8'h05);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule